// File: doc/BRIEF.md
# Gated Frequency Counter with Split Mode

This block measures how often a digital signal toggles. After a start command it waits for the next tick of an internal millisecond timebase. It then opens a gate for 1, 4, 16 or 64 ms and counts rising edges of the measured input into a 20-bit register. When the gate closes, the value freezes and a completion flag goes high. The value stays readable until the next start.

Two other behaviours share the same 20 storage bits. In split mode the register becomes two independent binary counters. The low 12 bits count edges on one auxiliary pin and the high 8 bits count edges on a second auxiliary pin. In timer mode the register counts timebase ticks from the start command onwards. Split mode and timer mode have no gate window and run until the next start. Every count saturates at all ones and raises a sticky overflow flag. Every count input passes through a two-flop synchroniser with a rising-edge detector.

Top module: `gate_freq_counter`

## Requirements
- R1: After reset, `result` is 0 and `done`, `overflow` and `gate_active` are all low.
- R2: A high `start` makes `result` read 0 and `done` and `overflow` read low one clock later. `start` also captures `gate_sel` and `mode_sel`. Changing those inputs later has no effect until the next start.
- R3: In frequency mode (`mode_sel` 0 or 3), `gate_active` rises on the first millisecond tick after start, which is within `TICKS_PER_MS` clocks. It then stays high for exactly (1 << 2*gate_sel) × `TICKS_PER_MS` clocks. So gate_sel 0 gives 1 ms, 1 gives 4 ms, 2 gives 16 ms and 3 gives 64 ms.
- R4: In frequency mode, each synchronised rising edge of `sig_in` that falls inside the gate adds one to `result`. Edges on `aux_a_in` and `aux_b_in` are ignored, and so are edges that arrive while the gate is closed.
- R5: `done` rises on the same clock edge on which `gate_active` falls. While `done` stays high, `result` does not change, even if more edges arrive.
- R6: A one-cycle `rd` pulse clears `done` and leaves `result` unchanged. A new start also clears `done`.
- R7: In split mode (`mode_sel` 1), counting starts from the start command. `result[11:0]` counts rising edges of `aux_a_in` and `result[19:12]` counts rising edges of `aux_b_in`. `sig_in` is ignored, `gate_active` stays low and `done` stays low.
- R8: Every counter, or counter field, that would pass all ones instead holds at all ones and sets `overflow`. A saturated field does not disturb the other field. `overflow` stays set until the next start.
- R9: In timer mode (`mode_sel` 2), `result` increases by exactly one per millisecond tick from start onwards. Over any window of k × `TICKS_PER_MS` clocks it grows by k. Edges on the count inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also drives the millisecond timebase |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_in | input | 1 | Measured signal (frequency mode) |
| aux_a_in | input | 1 | Count input for the 12-bit field (split mode) |
| aux_b_in | input | 1 | Count input for the 8-bit field (split mode) |
| start | input | 1 | Start command; clears and restarts the block |
| gate_sel | input | 2 | Gate length code, captured at start |
| mode_sel | input | 2 | 0/3 frequency, 1 split, 2 timer; captured at start |
| rd | input | 1 | Read acknowledge; clears `done` |
| result | output | 20 | Count value |
| done | output | 1 | Frequency measurement complete |
| overflow | output | 1 | A counter saturated since the last start |
| gate_active | output | 1 | Gate window open |

## Verification
In frequency mode, bursts of different lengths are sent inside gates of each length. An exact count shows that the sampling is edge-based and that the gate length is right. The gates are also run with no edges at all, which pins the window length down to the clock. Edges sent after the gate has closed, and edges sent on the auxiliary pins, must leave the result unchanged. These tests separate gate control from the counter path.

In split mode, unequal edge counts go to the two auxiliary pins while the main input also toggles. This exposes any crossed field or leaked input. A long burst on the 8-bit pin shows saturation and the overflow flag without disturbing the 12-bit field.

In timer mode, the result is sampled over a fixed window while the inputs toggle. This shows that the timer counts ticks and not edges.

// File: rtl/fc_pkg.sv
package fc_pkg;

    typedef enum logic [1:0] {
        MODE_FREQ  = 2'd0,
        MODE_SPLIT = 2'd1,
        MODE_TIMER = 2'd2,
        MODE_FREQ2 = 2'd3
    } fc_mode_e;

    typedef enum logic [1:0] {
        GS_IDLE = 2'd0,
        GS_ARM  = 2'd1,
        GS_OPEN = 2'd2,
        GS_FREE = 2'd3
    } gate_state_e;

    function automatic logic mode_is_free(input logic [1:0] m);
        return (m == MODE_SPLIT) || (m == MODE_TIMER);
    endfunction

endpackage

// File: rtl/fc_edge_sync.sv
module fc_edge_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] rise
);
    typedef struct packed {
        logic [N-1:0] meta;
        logic [N-1:0] sync;
        logic [N-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = din;
        st_d.sync = st_q.meta;
        st_d.prev = st_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_rise
        assign rise[i] = st_q.sync[i] & ~st_q.prev[i];
    end
endmodule

// File: rtl/fc_timebase.sv
module fc_timebase #(
    parameter int TICKS_PER_MS = 50000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int DIV_W = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(TICKS_PER_MS - 1);

    logic [DIV_W-1:0] div_d, div_q;

    always_comb begin
        if (div_q == LAST) div_d = '0;
        else               div_d = div_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign tick = (div_q == LAST);
endmodule

// File: rtl/fc_gate_ctrl.sv
module fc_gate_ctrl
    import fc_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic             free_mode,
    input  logic [SEL_W-1:0] sel,
    output logic             gate_open,
    output logic             gate_close,
    output logic             free_run
);
    localparam int LEFT_W = 2 * ((1 << SEL_W) - 1);

    typedef struct packed {
        gate_state_e      state;
        logic [SEL_W-1:0] sel;
        logic [LEFT_W-1:0] left;
    } gate_t;

    gate_t g_d, g_q;
    logic [LEFT_W:0] len_ms;
    logic [LEFT_W:0] len_m1;

    always_comb begin
        len_ms = {{LEFT_W{1'b0}}, 1'b1} << (2 * g_q.sel);
        len_m1 = len_ms - 1'b1;
        g_d    = g_q;
        if (start) begin
            g_d.sel   = sel;
            g_d.left  = '0;
            g_d.state = free_mode ? GS_FREE : GS_ARM;
        end else begin
            case (g_q.state)
                GS_ARM: if (tick) begin
                    g_d.state = GS_OPEN;
                    g_d.left  = len_m1[LEFT_W-1:0];
                end
                GS_OPEN: if (tick) begin
                    if (g_q.left == '0) g_d.state = GS_IDLE;
                    else                g_d.left  = g_q.left - 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '{state: GS_IDLE, sel: '0, left: '0};
        else        g_q <= g_d;
    end

    assign gate_open  = (g_q.state == GS_OPEN);
    assign gate_close = gate_open && tick && (g_q.left == '0);
    assign free_run   = (g_q.state == GS_FREE);
endmodule

// File: rtl/gate_freq_counter.sv
module gate_freq_counter
    import fc_pkg::*;
#(
    parameter int TICKS_PER_MS = 50000,
    parameter int CNT_W        = 20,
    parameter int LO_W         = 12,
    parameter int SEL_W        = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sig_in,
    input  logic             aux_a_in,
    input  logic             aux_b_in,
    input  logic             start,
    input  logic [SEL_W-1:0] gate_sel,
    input  logic [1:0]       mode_sel,
    input  logic             rd,
    output logic [CNT_W-1:0] result,
    output logic             done,
    output logic             overflow,
    output logic             gate_active
);
    localparam int HI_W = CNT_W - LO_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        fc_mode_e         mode;
        logic             done;
        logic             ovf;
    } core_t;

    core_t c_d, c_q;

    logic       tick;
    logic [2:0] rise;
    logic       g_open, g_close, g_free;

    fc_timebase #(.TICKS_PER_MS(TICKS_PER_MS)) u_tb (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    fc_edge_sync #(.N(3)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .din({aux_b_in, aux_a_in, sig_in}),
        .rise(rise)
    );

    fc_gate_ctrl #(.SEL_W(SEL_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
        .free_mode(mode_is_free(mode_sel)), .sel(gate_sel),
        .gate_open(g_open), .gate_close(g_close), .free_run(g_free)
    );

    logic [LO_W-1:0] lo_q;
    logic [HI_W-1:0] hi_q;
    assign lo_q = c_q.cnt[LO_W-1:0];
    assign hi_q = c_q.cnt[CNT_W-1:LO_W];

    always_comb begin
        c_d = c_q;
        if (start) begin
            c_d.cnt  = '0;
            c_d.done = 1'b0;
            c_d.ovf  = 1'b0;
            c_d.mode = fc_mode_e'(mode_sel);
        end else begin
            case (c_q.mode)
                MODE_SPLIT: if (g_free) begin
                    if (rise[1]) begin
                        if (&lo_q) c_d.ovf = 1'b1;
                        else       c_d.cnt[LO_W-1:0] = lo_q + 1'b1;
                    end
                    if (rise[2]) begin
                        if (&hi_q) c_d.ovf = 1'b1;
                        else       c_d.cnt[CNT_W-1:LO_W] = hi_q + 1'b1;
                    end
                end
                MODE_TIMER: if (g_free && tick) begin
                    if (&c_q.cnt) c_d.ovf = 1'b1;
                    else          c_d.cnt = c_q.cnt + 1'b1;
                end
                default: if (g_open && rise[0]) begin
                    if (&c_q.cnt) c_d.ovf = 1'b1;
                    else          c_d.cnt = c_q.cnt + 1'b1;
                end
            endcase
            if (g_close)  c_d.done = 1'b1;
            else if (rd)  c_d.done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{cnt: '0, mode: MODE_FREQ, done: 1'b0, ovf: 1'b0};
        else        c_q <= c_d;
    end

    assign result      = c_q.cnt;
    assign done        = c_q.done;
    assign overflow    = c_q.ovf;
    assign gate_active = g_open;
endmodule

// File: rtl/fc_checker.sv
module fc_checker #(
    parameter int TPM   = 50000,
    parameter int CNT_W = 20,
    parameter int SEL_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [SEL_W-1:0] gate_sel,
    input logic [CNT_W-1:0] result,
    input logic             done,
    input logic             overflow,
    input logic             gate_active
);
    int unsigned gate_cnt;
    int unsigned exp_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_cnt <= 0;
            exp_len  <= TPM;
        end else if (start) begin
            gate_cnt <= 0;
            exp_len  <= (32'd1 << (2 * gate_sel)) * TPM;
        end else if (gate_active) begin
            gate_cnt <= gate_cnt + 1;
        end
    end

    assert_gate_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(gate_active) && !$past(start)) |-> (gate_cnt == exp_len));

    assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start) |-> (result == '0 && !done && !overflow));

    assert_done_at_close_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $fell(gate_active));

    assert_result_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(done)) |-> $stable(result));

    assert_no_gate_when_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !gate_active);

    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(overflow) && !$past(start)) |-> overflow);
endmodule

bind gate_freq_counter fc_checker #(
    .TPM(TICKS_PER_MS), .CNT_W(CNT_W), .SEL_W(SEL_W)
) u_fc_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .gate_sel(gate_sel),
    .result(result), .done(done), .overflow(overflow),
    .gate_active(gate_active)
);

// File: tb/sim_gate_freq_counter.sv
module sim_gate_freq_counter;
    localparam int TPM = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sig_in = 1'b0, aux_a_in = 1'b0, aux_b_in = 1'b0;
    logic        start = 1'b0, rd = 1'b0;
    logic [1:0]  gate_sel = '0, mode_sel = '0;
    logic [19:0] result;
    logic        done, overflow, gate_active;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    gate_freq_counter #(.TICKS_PER_MS(TPM)) u0 (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .aux_a_in(aux_a_in),
        .aux_b_in(aux_b_in), .start(start), .gate_sel(gate_sel),
        .mode_sel(mode_sel), .rd(rd), .result(result), .done(done),
        .overflow(overflow), .gate_active(gate_active)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_start(input logic [1:0] m, input logic [1:0] s);
        mode_sel = m; gate_sel = s; start = 1'b1;
        cyc(1);
        start = 1'b0;
    endtask

    // which: 0 sig_in, 1 aux_a_in, 2 aux_b_in, 3 all three
    task automatic pulses(input int which, input int n);
        for (int i = 0; i < n; i++) begin
            if (which == 0 || which == 3) sig_in = 1'b1;
            if (which == 1 || which == 3) aux_a_in = 1'b1;
            if (which == 2 || which == 3) aux_b_in = 1'b1;
            cyc(2);
            sig_in = 1'b0; aux_a_in = 1'b0; aux_b_in = 1'b0;
            cyc(2);
        end
    endtask

    task automatic wait_gate_rise(output int waited);
        waited = 0;
        while (!gate_active && waited < 100) begin cyc(1); waited++; end
    endtask

    task automatic wait_done();
        int w = 0;
        while (!done && w < 2000) begin cyc(1); w++; end
    endtask

    task automatic t_reset();
        check("R1 result", result, 0);
        check("R1 done", done, 0);
        check("R1 overflow", overflow, 0);
        check("R1 gate_active", gate_active, 0);
    endtask

    task automatic t_gate_len(input logic [1:0] s);
        int w;
        int len = 0;
        do_start(2'd0, s);
        check("R2 result cleared", result, 0);
        check("R2 done cleared", done, 0);
        wait_gate_rise(w);
        check("R3 gate opens within one ms", (w <= TPM) ? 1 : 0, 1);
        while (gate_active && len < 1000) begin cyc(1); len++; end
        check("R3 gate length", len, (1 << (2 * s)) * TPM);
        check("R5 done at close", done, 1);
        check("R4 no edges gives zero", result, 0);
        rd = 1'b1; cyc(1); rd = 1'b0;
    endtask

    task automatic t_freq(input logic [1:0] s, input int n);
        int w;
        do_start(2'd0, s);
        mode_sel = 2'd1; gate_sel = 2'd0;   // R2: ignored after start
        wait_gate_rise(w);
        cyc(2);
        pulses(0, n);
        wait_done();
        check("R4 edges counted in gate", result, n);
        check("R2 captured mode/gate kept", done, 1);
        pulses(0, 5);
        check("R5 result frozen after close", result, n);
        check("R5 done held", done, 1);
        rd = 1'b1; cyc(1); rd = 1'b0;
        check("R6 rd clears done", done, 0);
        check("R6 rd keeps result", result, n);
    endtask

    task automatic t_freq_aux_ignored();
        int w;
        do_start(2'd0, 2'd1);
        wait_gate_rise(w);
        cyc(2);
        pulses(1, 3);
        pulses(2, 2);
        pulses(0, 3);
        wait_done();
        check("R4 aux ignored in frequency mode", result, 3);
        do_start(2'd3, 2'd0);
        check("R6 start clears done", done, 0);
        wait_done();
    endtask

    task automatic t_split();
        do_start(2'd1, 2'd0);
        pulses(1, 5);
        pulses(2, 3);
        pulses(0, 4);
        pulses(3, 2);
        cyc(5);
        check("R7 low field counts aux_a", result[11:0], 7);
        check("R7 high field counts aux_b", result[19:12], 5);
        check("R7 no gate in split", gate_active, 0);
        check("R7 no done in split", done, 0);
    endtask

    task automatic t_saturate();
        do_start(2'd1, 2'd0);
        pulses(2, 260);
        cyc(5);
        check("R8 high field saturates", result[19:12], 255);
        check("R8 overflow set", overflow, 1);
        check("R8 low field untouched", result[11:0], 0);
        pulses(1, 2);
        cyc(5);
        check("R8 low field still counts", result[11:0], 2);
        check("R8 overflow sticky", overflow, 1);
        do_start(2'd0, 2'd0);
        check("R8 start clears overflow", overflow, 0);
        wait_done();
    endtask

    task automatic t_timer();
        logic [19:0] r0;
        do_start(2'd2, 2'd0);
        cyc(3);
        r0 = result;
        fork
            cyc(5 * TPM);
            pulses(3, 12);
        join
        check("R9 timer advances once per ms", result - r0, 5);
        check("R9 no gate in timer", gate_active, 0);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        t_reset();
        for (int s = 0; s < 4; s++) t_gate_len(2'(s));
        t_freq(2'd0, 1);
        t_freq(2'd1, 7);
        t_freq(2'd2, 30);
        t_freq(2'd3, 100);
        t_freq_aux_ignored();
        t_split();
        t_saturate();
        t_timer();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule